// File: doc/BRIEF.md
# Trigger and Reset Command Front End

This block takes the timing commands that steer a multi-channel time digitizer: trigger, bunch-count reset, event-count reset and global reset. They arrive either on three separate direct lines or as short framed codes on a single serial line, and a configuration bit picks the source. The block decodes them and keeps two counters. The bunch counter gives the trigger time tag. It counts once per clock, restarts at a programmable offset and wraps at a programmable roll-over value. The event counter gives the event identifier. It restarts at its own programmable offset.

On every trigger the block writes the current time tag and event identifier into a small trigger queue, which the matching logic downstream reads. If the queue is full, the trigger cannot be stored. The block then counts the missed triggers and, as soon as a slot is free, writes one marker entry. That entry carries the number of missed triggers and the identifier of the first one, so the downstream event numbering stays aligned. The block also produces a one-cycle master-reset pulse and one-cycle separator-request pulses.

Top module: `trig_cmd_frontend`

## Requirements
- R1: While `rst_n` is low, `bunch_now`, `event_now`, `tag_valid`, `master_reset` and `sep_req` are all 0.
- R2: `bunch_now` rises by one per clock and returns to 0 on the clock after it equals `cfg_rollover`. A bunch-count reset loads `cfg_bunch_offset`. On a direct line sampled at edge k, `bunch_now` shows the offset after edge k+1.
- R3: An event-count reset loads `cfg_event_offset` into `event_now`. Every trigger, whether stored or lost, raises `event_now` by one modulo 2^EVT_W.
- R4: A stored trigger writes an entry with lost flag 0, `tag_time` equal to the bunch value in the cycle the trigger takes effect, and `tag_event` equal to the identifier before the increment. Entries leave in arrival order, and the head is shown whenever `tag_valid` is 1. A high `tag_pop` sampled at an edge removes the head.
- R5: On the serial line, idle is 0. A command is a start bit 1 followed by two code bits, high bit first: 00 trigger, 01 bunch reset, 10 event reset, 11 global reset. The two code bits are never taken as a start bit.
- R6: A serial command takes effect exactly three clocks later than the same command on a direct line sampled at the start-bit edge.
- R7: With `cfg_encoded` = 1 the direct lines have no effect. With `cfg_encoded` = 0 the serial line has no effect.
- R8: A global-reset command gives a one-cycle `master_reset` pulse only when `cfg_mreset_en` is 1. The pulse appears two edges after the command is decoded, the same spacing as the event-count load.
- R9: A bunch-count reset gives a one-cycle `sep_req` pulse when `cfg_sep_bcr_en` is 1. An event-count reset does the same when `cfg_sep_ecr_en` is 1. The pulse is visible in the same cycle as the counter load.
- R10: A trigger is lost when the queue is full, or when earlier lost triggers are still pending. Once the queue has room and no trigger is present, one entry is written with lost flag 1, `tag_time` equal to the lost count (zero-extended) and `tag_event` equal to the identifier of the first lost trigger. The lost count then clears.
- R11: The lost count saturates at 2^LOST_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_encoded | input | 1 | 1: serial command line, 0: direct lines |
| cfg_mreset_en | input | 1 | Allow global reset to pulse master_reset |
| cfg_sep_bcr_en | input | 1 | Separator request on bunch-count reset |
| cfg_sep_ecr_en | input | 1 | Separator request on event-count reset |
| cfg_rollover | input | BUNCH_W | Last bunch count before wrap to 0 |
| cfg_bunch_offset | input | BUNCH_W | Value loaded by bunch-count reset |
| cfg_event_offset | input | EVT_W | Value loaded by event-count reset |
| cmd_ser | input | 1 | Serial command line |
| dir_trig | input | 1 | Direct trigger line |
| dir_bcr | input | 1 | Direct bunch-count reset line |
| dir_ecr | input | 1 | Direct event-count reset line |
| tag_pop | input | 1 | Remove queue head |
| tag_valid | output | 1 | Queue not empty |
| tag_lost | output | 1 | Head entry is a lost-trigger marker |
| tag_time | output | BUNCH_W | Head time tag, or lost count |
| tag_event | output | EVT_W | Head event identifier |
| bunch_now | output | BUNCH_W | Current bunch count |
| event_now | output | EVT_W | Current event identifier |
| master_reset | output | 1 | One-cycle master reset pulse |
| sep_req | output | 1 | One-cycle separator request |

## Verification
The checker takes three things for granted. Configuration inputs change only while no command is in flight. In serial mode, commands never overlap, so at most one decoded command is active per cycle. The direct lines are low at the moment the mode bit changes. The bench keeps to these rules: it writes configuration between commands, sends serial frames back to back only after the previous frame has ended, and drops every direct line before it switches modes. It runs sweeps of the roll-over and offset values, trigger gaps from zero to four cycles, event-identifier wrap, and runs of consecutive triggers that overfill the queue past the lost-count limit.

// File: rtl/trig_cmd_pkg.sv
package trig_cmd_pkg;

   typedef struct packed {
      logic trig;
      logic bcr;
      logic ecr;
      logic grst;
   } trig_cmd_t;

   typedef enum logic [1:0] {
      DEC_IDLE = 2'd0,
      DEC_HI   = 2'd1,
      DEC_LO   = 2'd2
   } dec_state_e;

   localparam logic [1:0] CODE_TRIG = 2'b00;
   localparam logic [1:0] CODE_BCR  = 2'b01;
   localparam logic [1:0] CODE_ECR  = 2'b10;
   localparam logic [1:0] CODE_GRST = 2'b11;

   localparam trig_cmd_t CMD_NONE = '0;

   function automatic trig_cmd_t code_to_cmd(input logic [1:0] code);
      trig_cmd_t c;
      c = CMD_NONE;
      case (code)
         CODE_TRIG: c.trig = 1'b1;
         CODE_BCR:  c.bcr  = 1'b1;
         CODE_ECR:  c.ecr  = 1'b1;
         default:   c.grst = 1'b1;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/trig_cmd_decoder.sv
module trig_cmd_decoder
   import trig_cmd_pkg::*;
#(
   parameter int ALIGN_STAGES = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cfg_encoded,
   input  logic      ser_i,
   input  logic      dir_trig_i,
   input  logic      dir_bcr_i,
   input  logic      dir_ecr_i,
   output trig_cmd_t cmd_o
);

   dec_state_e state_q;
   logic       hi_q;
   trig_cmd_t  dec_q;
   trig_cmd_t  dir_q;
   trig_cmd_t  enc_cmd;

   // frame capture: start bit, then two code bits (high first)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= DEC_IDLE;
         hi_q    <= 1'b0;
         dec_q   <= CMD_NONE;
      end else begin
         dec_q <= CMD_NONE;
         case (state_q)
            DEC_IDLE: if (cfg_encoded && ser_i) state_q <= DEC_HI;
            DEC_HI: begin
               hi_q    <= ser_i;
               state_q <= DEC_LO;
            end
            DEC_LO: begin
               dec_q   <= code_to_cmd({hi_q, ser_i});
               state_q <= DEC_IDLE;
            end
            default: state_q <= DEC_IDLE;
         endcase
      end
   end

   // direct lines: one register stage, blocked in serial mode
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= CMD_NONE;
      end else if (cfg_encoded) begin
         dir_q <= CMD_NONE;
      end else begin
         dir_q.trig <= dir_trig_i;
         dir_q.bcr  <= dir_bcr_i;
         dir_q.ecr  <= dir_ecr_i;
         dir_q.grst <= 1'b0;
      end
   end

   // alignment stages: serial path lags direct path by ALIGN_STAGES + 2
   generate
      if (ALIGN_STAGES == 0) begin : g_no_align
         assign enc_cmd = dec_q;
      end else begin : g_align
         trig_cmd_t pipe_q [ALIGN_STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < ALIGN_STAGES; i++) pipe_q[i] <= CMD_NONE;
            end else begin
               pipe_q[0] <= dec_q;
               for (int i = 1; i < ALIGN_STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign enc_cmd = pipe_q[ALIGN_STAGES-1];
      end
   endgenerate

   assign cmd_o = trig_cmd_t'(enc_cmd | dir_q);

endmodule

// File: rtl/trig_time_counters.sv
module trig_time_counters
   import trig_cmd_pkg::*;
#(
   parameter int BUNCH_W = 12,
   parameter int EVT_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  trig_cmd_t          cmd_i,
   input  logic [BUNCH_W-1:0] cfg_rollover,
   input  logic [BUNCH_W-1:0] cfg_bunch_offset,
   input  logic [EVT_W-1:0]   cfg_event_offset,
   output logic [BUNCH_W-1:0] bunch_o,
   output logic [EVT_W-1:0]   event_o
);

   logic [BUNCH_W-1:0] bunch_q;
   logic [EVT_W-1:0]   event_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                     bunch_q <= '0;
      else if (cmd_i.bcr)             bunch_q <= cfg_bunch_offset;
      else if (bunch_q == cfg_rollover) bunch_q <= '0;
      else                            bunch_q <= bunch_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          event_q <= '0;
      else if (cmd_i.ecr)  event_q <= cfg_event_offset;
      else if (cmd_i.trig) event_q <= event_q + 1'b1;
   end

   assign bunch_o = bunch_q;
   assign event_o = event_q;

endmodule

// File: rtl/trig_tag_fifo.sv
module trig_tag_fifo #(
   parameter int WIDTH = 25,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             pop_i,
   output logic             full_o,
   output logic             valid_o,
   output logic [WIDTH-1:0] data_o
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FILL_MAX  = CW'(DEPTH);

   logic [WIDTH-1:0] slot_q [DEPTH];
   logic [AW-1:0]    wr_q;
   logic [AW-1:0]    rd_q;
   logic [CW-1:0]    fill_q;
   logic             do_push;
   logic             do_pop;

   assign full_o  = (fill_q == FILL_MAX);
   assign valid_o = (fill_q != '0);
   assign do_push = push_i && !full_o;
   assign do_pop  = pop_i && valid_o;
   assign data_o  = slot_q[rd_q];

   always_ff @(posedge clk) begin
      if (do_push) slot_q[wr_q] <= data_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= '0;
         rd_q   <= '0;
         fill_q <= '0;
      end else begin
         if (do_push) wr_q <= (wr_q == LAST_SLOT) ? '0 : wr_q + 1'b1;
         if (do_pop)  rd_q <= (rd_q == LAST_SLOT) ? '0 : rd_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill_q <= fill_q + 1'b1;
            2'b01:   fill_q <= fill_q - 1'b1;
            default: fill_q <= fill_q;
         endcase
      end
   end

endmodule

// File: rtl/trig_cmd_frontend.sv
module trig_cmd_frontend
   import trig_cmd_pkg::*;
#(
   parameter int BUNCH_W    = 12,
   parameter int EVT_W      = 12,
   parameter int FIFO_DEPTH = 8,
   parameter int LOST_W     = 4,
   parameter int ENC_ALIGN  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_encoded,
   input  logic               cfg_mreset_en,
   input  logic               cfg_sep_bcr_en,
   input  logic               cfg_sep_ecr_en,
   input  logic [BUNCH_W-1:0] cfg_rollover,
   input  logic [BUNCH_W-1:0] cfg_bunch_offset,
   input  logic [EVT_W-1:0]   cfg_event_offset,
   input  logic               cmd_ser,
   input  logic               dir_trig,
   input  logic               dir_bcr,
   input  logic               dir_ecr,
   input  logic               tag_pop,
   output logic               tag_valid,
   output logic               tag_lost,
   output logic [BUNCH_W-1:0] tag_time,
   output logic [EVT_W-1:0]   tag_event,
   output logic [BUNCH_W-1:0] bunch_now,
   output logic [EVT_W-1:0]   event_now,
   output logic               master_reset,
   output logic               sep_req
);

   localparam int ENTRY_W = 1 + BUNCH_W + EVT_W;
   localparam logic [LOST_W-1:0] LOST_MAX = {LOST_W{1'b1}};

   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if (LOST_W < 1 || LOST_W > BUNCH_W) begin : g_bad_lost
         $error("LOST_W must lie in 1..BUNCH_W");
      end
      if (ENC_ALIGN < 0) begin : g_bad_align
         $error("ENC_ALIGN must not be negative");
      end
   endgenerate

   trig_cmd_t          cmd_w;
   logic [BUNCH_W-1:0] bunch_w;
   logic [EVT_W-1:0]   event_w;
   logic               fifo_full;
   logic               push;
   logic [ENTRY_W-1:0] push_data;
   logic [ENTRY_W-1:0] head_data;
   logic [LOST_W-1:0]  lost_cnt_q;
   logic [EVT_W-1:0]   first_lost_q;
   logic               backlog;

   trig_cmd_decoder #(.ALIGN_STAGES(ENC_ALIGN)) dec_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_encoded (cfg_encoded),
      .ser_i       (cmd_ser),
      .dir_trig_i  (dir_trig),
      .dir_bcr_i   (dir_bcr),
      .dir_ecr_i   (dir_ecr),
      .cmd_o       (cmd_w)
   );

   trig_time_counters #(.BUNCH_W(BUNCH_W), .EVT_W(EVT_W)) cnt_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .cmd_i            (cmd_w),
      .cfg_rollover     (cfg_rollover),
      .cfg_bunch_offset (cfg_bunch_offset),
      .cfg_event_offset (cfg_event_offset),
      .bunch_o          (bunch_w),
      .event_o          (event_w)
   );

   assign backlog = (lost_cnt_q != '0);

   // a trigger is stored only when nothing is pending; a lost marker
   // waits for a free slot in a cycle without trigger
   always_comb begin
      push      = 1'b0;
      push_data = {1'b0, bunch_w, event_w};
      if (cmd_w.trig) begin
         push = !fifo_full && !backlog;
      end else if (backlog && !fifo_full) begin
         push      = 1'b1;
         push_data = {1'b1, BUNCH_W'(lost_cnt_q), first_lost_q};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lost_cnt_q   <= '0;
         first_lost_q <= '0;
      end else if (cmd_w.trig && (fifo_full || backlog)) begin
         if (!backlog) first_lost_q <= event_w;
         if (lost_cnt_q != LOST_MAX) lost_cnt_q <= lost_cnt_q + 1'b1;
      end else if (backlog && !fifo_full) begin
         lost_cnt_q <= '0;
      end
   end

   trig_tag_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) fifo_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .data_i  (push_data),
      .pop_i   (tag_pop),
      .full_o  (fifo_full),
      .valid_o (tag_valid),
      .data_o  (head_data)
   );

   assign tag_lost  = head_data[ENTRY_W-1];
   assign tag_time  = head_data[EVT_W +: BUNCH_W];
   assign tag_event = head_data[EVT_W-1:0];
   assign bunch_now = bunch_w;
   assign event_now = event_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         master_reset <= 1'b0;
         sep_req      <= 1'b0;
      end else begin
         master_reset <= cmd_w.grst && cfg_mreset_en;
         sep_req      <= (cmd_w.bcr && cfg_sep_bcr_en) || (cmd_w.ecr && cfg_sep_ecr_en);
      end
   end

endmodule

// File: rtl/trig_cmd_frontend_chk.sv
module trig_cmd_frontend_chk
   import trig_cmd_pkg::*;
#(
   parameter int BUNCH_W = 12,
   parameter int EVT_W   = 12,
   parameter int LOST_W  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_encoded,
   input logic               cfg_mreset_en,
   input logic               cfg_sep_bcr_en,
   input logic               cfg_sep_ecr_en,
   input logic [BUNCH_W-1:0] cfg_rollover,
   input logic [EVT_W-1:0]   cfg_event_offset,
   input trig_cmd_t          cmd_i,
   input logic [BUNCH_W-1:0] bunch_now,
   input logic [EVT_W-1:0]   event_now,
   input logic [LOST_W-1:0]  lost_cnt_i,
   input logic               master_reset,
   input logic               sep_req
);

   localparam logic [LOST_W-1:0] LOST_MAX = {LOST_W{1'b1}};

   assert_roll_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_i.bcr && bunch_now == cfg_rollover) |=> bunch_now == '0);

   assert_evt_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i.ecr |=> event_now == $past(cfg_event_offset));

   assert_evt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i.trig && !cmd_i.ecr) |=> event_now == EVT_W'($past(event_now) + 1'b1));

   assert_single_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_encoded |-> $onehot0(cmd_i));

   assert_mreset_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      master_reset |-> $past(cmd_i.grst && cfg_mreset_en));

   assert_sep_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sep_req |-> $past((cmd_i.bcr && cfg_sep_bcr_en) || (cmd_i.ecr && cfg_sep_ecr_en)));

   assert_backlog_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_cnt_i != '0 && cmd_i.trig) |=> lost_cnt_i != '0);

   assert_lost_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (lost_cnt_i == LOST_MAX && cmd_i.trig) |=> lost_cnt_i == LOST_MAX);

endmodule

bind trig_cmd_frontend trig_cmd_frontend_chk #(
   .BUNCH_W (BUNCH_W),
   .EVT_W   (EVT_W),
   .LOST_W  (LOST_W)
) chk_i (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_encoded      (cfg_encoded),
   .cfg_mreset_en    (cfg_mreset_en),
   .cfg_sep_bcr_en   (cfg_sep_bcr_en),
   .cfg_sep_ecr_en   (cfg_sep_ecr_en),
   .cfg_rollover     (cfg_rollover),
   .cfg_event_offset (cfg_event_offset),
   .cmd_i            (cmd_w),
   .bunch_now        (bunch_now),
   .event_now        (event_now),
   .lost_cnt_i       (lost_cnt_q),
   .master_reset     (master_reset),
   .sep_req          (sep_req)
);

// File: tb/trig_cmd_frontend_tb_top.sv
module trig_cmd_frontend_tb_top;

   localparam int BW = 12;
   localparam int EW = 12;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cfg_encoded, cfg_mreset_en, cfg_sep_bcr_en, cfg_sep_ecr_en;
   logic [BW-1:0] cfg_rollover, cfg_bunch_offset;
   logic [EW-1:0] cfg_event_offset;
   logic          cmd_ser, dir_trig, dir_bcr, dir_ecr, tag_pop;
   logic          tag_valid, tag_lost, master_reset, sep_req;
   logic [BW-1:0] tag_time, bunch_now;
   logic [EW-1:0] tag_event, event_now;

   always #2 clk = ~clk;

   trig_cmd_frontend dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_encoded(cfg_encoded), .cfg_mreset_en(cfg_mreset_en),
      .cfg_sep_bcr_en(cfg_sep_bcr_en), .cfg_sep_ecr_en(cfg_sep_ecr_en),
      .cfg_rollover(cfg_rollover), .cfg_bunch_offset(cfg_bunch_offset),
      .cfg_event_offset(cfg_event_offset), .cmd_ser(cmd_ser), .dir_trig(dir_trig),
      .dir_bcr(dir_bcr), .dir_ecr(dir_ecr), .tag_pop(tag_pop), .tag_valid(tag_valid),
      .tag_lost(tag_lost), .tag_time(tag_time), .tag_event(tag_event),
      .bunch_now(bunch_now), .event_now(event_now), .master_reset(master_reset),
      .sep_req(sep_req)
   );

   int checks = 0;
   int fails  = 0;
   int n      = 0;
   int base_off, base_n, roll;
   int exp_evt, first_lost;
   int q_n = 0;
   int e_lost [32];
   int e_tag  [32];
   int e_evt  [32];

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      n++;
   endtask

   function automatic int exp_bunch(input int nn);
      return (base_off + nn - base_n) % (roll + 1);
   endfunction

   task automatic record(input int lf, input int tg, input int ev);
      e_lost[q_n] = lf;
      e_tag[q_n]  = tg;
      e_evt[q_n]  = ev;
      q_n++;
   endtask

   // line: 0 trigger, 1 bunch reset, 2 event reset
   task automatic dir_pulse(input int line);
      dir_trig = (line == 0);
      dir_bcr  = (line == 1);
      dir_ecr  = (line == 2);
      tick();
      dir_trig = 1'b0;
      dir_bcr  = 1'b0;
      dir_ecr  = 1'b0;
   endtask

   task automatic enc_send(input logic [1:0] code);
      cmd_ser = 1'b1;
      tick();
      cmd_ser = code[1];
      tick();
      cmd_ser = code[0];
      tick();
      cmd_ser = 1'b0;
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < q_n; i++) begin
         check_eq(req, "valid", tag_valid, 1);
         check_eq(req, "lost flag", tag_lost, e_lost[i]);
         check_eq(req, "time", tag_time, e_tag[i]);
         check_eq(req, "event", tag_event, e_evt[i]);
         tag_pop = 1'b1;
         tick();
         tag_pop = 1'b0;
      end
      q_n = 0;
      tick();
      check_eq(req, "empty after drain", tag_valid, 0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      cfg_encoded = 1'b0; cfg_mreset_en = 1'b0;
      cfg_sep_bcr_en = 1'b0; cfg_sep_ecr_en = 1'b0;
      cfg_rollover = 12'hFFF; cfg_bunch_offset = '0; cfg_event_offset = '0;
      cmd_ser = 1'b0; dir_trig = 1'b0; dir_bcr = 1'b0; dir_ecr = 1'b0; tag_pop = 1'b0;
      repeat (4) tick();
      check_eq("R1", "bunch in reset", bunch_now, 0);
      check_eq("R1", "event in reset", event_now, 0);
      check_eq("R1", "valid in reset", tag_valid, 0);
      check_eq("R1", "master_reset in reset", master_reset, 0);
      check_eq("R1", "sep_req in reset", sep_req, 0);
      rst_n = 1'b1;
      tick();

      // R2: small roll-over sweep after a direct bunch reset
      cfg_rollover = 12'd9; roll = 9;
      cfg_bunch_offset = 12'd3;
      dir_pulse(1);
      tick();
      check_eq("R2", "bunch after direct load", bunch_now, 3);
      check_eq("R9", "no separator when disabled", sep_req, 0);
      base_off = 3; base_n = n;
      for (int k = 1; k <= 24; k++) begin
         tick();
         check_eq("R2", "bunch sweep", bunch_now, exp_bunch(n));
      end

      // R3 and R9: event reset with separator
      cfg_event_offset = 12'h0A5;
      cfg_sep_ecr_en = 1'b1;
      dir_pulse(2);
      tick();
      check_eq("R3", "event offset load", event_now, 12'h0A5);
      check_eq("R9", "separator on event reset", sep_req, 1);
      tick();
      check_eq("R9", "separator one cycle", sep_req, 0);
      exp_evt = 12'h0A5;

      // R4: direct triggers with gaps 0..4
      cfg_rollover = 12'hFFF; roll = 4095;
      cfg_bunch_offset = 12'h100;
      cfg_sep_bcr_en = 1'b1;
      dir_pulse(1);
      tick();
      check_eq("R2", "bunch offset 0x100", bunch_now, 12'h100);
      check_eq("R9", "separator on bunch reset", sep_req, 1);
      base_off = 12'h100; base_n = n;
      for (int g = 0; g <= 4; g++) begin
         dir_trig = 1'b1;
         tick();
         record(0, exp_bunch(n), exp_evt);
         exp_evt = (exp_evt + 1) & 12'hFFF;
         dir_trig = 1'b0;
         repeat (g) tick();
      end
      tick(); tick();
      check_eq("R3", "event after triggers", event_now, exp_evt);
      drain("R4");

      // R7: serial line ignored in direct mode
      enc_send(2'b00);
      enc_send(2'b01);
      repeat (4) tick();
      check_eq("R7", "serial ignored: queue", tag_valid, 0);
      check_eq("R7", "serial ignored: event", event_now, exp_evt);
      check_eq("R7", "serial ignored: bunch", bunch_now, exp_bunch(n));
      // R7: direct lines ignored in serial mode
      cfg_encoded = 1'b1;
      tick(); tick();
      dir_pulse(0);
      dir_pulse(1);
      dir_pulse(2);
      repeat (3) tick();
      check_eq("R7", "direct ignored: queue", tag_valid, 0);
      check_eq("R7", "direct ignored: event", event_now, exp_evt);
      check_eq("R7", "direct ignored: bunch", bunch_now, exp_bunch(n));

      // R6: serial bunch reset lands three clocks later than direct
      cfg_bunch_offset = 12'h200;
      enc_send(2'b01);
      tick();
      check_eq("R6", "bunch not yet loaded", bunch_now, exp_bunch(n));
      tick();
      check_eq("R6", "bunch loaded by serial", bunch_now, 12'h200);
      base_off = 12'h200; base_n = n;

      // R5: serial triggers and event reset, with identifier wrap
      for (int t = 0; t < 2; t++) begin
         enc_send(2'b00);
         tick();
         record(0, exp_bunch(n), exp_evt);
         exp_evt = (exp_evt + 1) & 12'hFFF;
      end
      cfg_event_offset = 12'hFFE;
      enc_send(2'b10);
      tick(); tick();
      check_eq("R5", "serial event reset", event_now, 12'hFFE);
      exp_evt = 12'hFFE;
      for (int t = 0; t < 3; t++) begin
         enc_send(2'b00);
         tick();
         record(0, exp_bunch(n), exp_evt);
         exp_evt = (exp_evt + 1) & 12'hFFF;
      end
      tick(); tick();
      check_eq("R3", "event wrap", event_now, exp_evt);
      drain("R5");

      // R8: global reset gated, single pulse, code bits not restarting
      cfg_mreset_en = 1'b0;
      enc_send(2'b11);
      for (int k = 0; k < 4; k++) begin
         tick();
         check_eq("R8", "master_reset gated off", master_reset, 0);
      end
      cfg_mreset_en = 1'b1;
      enc_send(2'b11);
      tick();
      check_eq("R8", "master_reset not early", master_reset, 0);
      tick();
      check_eq("R8", "master_reset pulse", master_reset, 1);
      for (int k = 0; k < 4; k++) begin
         tick();
         check_eq("R5", "no phantom global reset", master_reset, 0);
      end
      check_eq("R5", "no phantom trigger", tag_valid, 0);
      check_eq("R5", "event unchanged", event_now, exp_evt);

      // R10: overflow by three triggers
      cfg_encoded = 1'b0;
      tick(); tick();
      cfg_bunch_offset = 12'h000;
      dir_pulse(1);
      tick();
      base_off = 0; base_n = n;
      dir_trig = 1'b1;
      for (int i = 0; i < 11; i++) begin
         tick();
         if (i < 8) record(0, exp_bunch(n), exp_evt);
         else if (i == 8) first_lost = exp_evt;
         exp_evt = (exp_evt + 1) & 12'hFFF;
      end
      dir_trig = 1'b0;
      repeat (3) tick();
      check_eq("R3", "lost triggers counted in event", event_now, exp_evt);
      record(1, 3, first_lost);
      drain("R10");

      // R11: lost count saturates
      dir_trig = 1'b1;
      for (int i = 0; i < 28; i++) begin
         tick();
         if (i < 8) record(0, exp_bunch(n), exp_evt);
         else if (i == 8) first_lost = exp_evt;
         exp_evt = (exp_evt + 1) & 12'hFFF;
      end
      dir_trig = 1'b0;
      repeat (3) tick();
      check_eq("R3", "event after saturation run", event_now, exp_evt);
      record(1, 15, first_lost);
      drain("R11");

      finish_run();
   end

endmodule